// File: doc/BRIEF.md
# Flash Instruction Cache with Sequential Prefetch

This block sits between a processor's instruction-fetch port and a slow, byte-wide flash read port. It keeps one small line of recently fetched code bytes and returns a byte with no wait when that byte is present. When the byte is absent, or the cache is switched off, it starts a flash read and holds the processor's ready low until the byte comes back.

When the processor consumes the final byte position of the line, the block reads ahead. It fetches the following bytes of code so that straight-line execution does not stall at the line boundary. A demand miss that arrives during read-ahead takes over the flash port as soon as the byte in flight has landed. Any read-ahead bytes not yet started are dropped. Read-ahead addresses wrap from the top of the flash range to address zero.

A two-bit control register sets the mode. One bit switches the cache off for debug. Writing it invalidates the line, and while it is set every fetch goes to flash and nothing is kept. The other bit stops read-ahead, so the line fills only on demand misses.

Top module: `flash_icache`

## Requirements
- R1: The control register reads back bit 1 as cache-off and bit 0 as read-ahead-off. Bits 7:2 always read 0. Both bits are 0 after reset.
- R2: A fetch whose upper address bits match the line tag, and whose byte-valid bit is set, is answered with ready in the same cycle and starts no flash read.
- R3: A missing fetch starts a flash read in the same cycle it is presented. Ready and the correct byte appear FLASH_LAT+1 cycles later, and the byte is then kept in the line.
- R4: With both control bits 0, serving a byte at line offset LINE_BYTES-1 starts reads of the next PF_BYTES sequential addresses. A later fetch of those addresses is a zero-wait hit.
- R5: While read-ahead-off is 1, every flash read is for the address the processor is currently requesting. The byte after a line-end byte therefore misses.
- R6: Any write with bit 1 set clears every valid bit by the next cycle. Clearing the bit later does not restore the old contents: a previously held byte misses.
- R7: While cache-off is 1, every fetch, including a repeat of the same address, waits for its own flash read, and no read-ahead is started.
- R8: A demand miss presented while a read-ahead byte is in flight is issued once that byte returns. The remaining read-ahead bytes are never read.
- R9: Read-ahead from the last address of the flash range continues at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data (bit 1 cache-off, bit 0 read-ahead-off) |
| cfg_rdata | output | 8 | Control register read value |
| cpu_req | input | 1 | Fetch request, held with its address until ready |
| cpu_addr | input | ADDR_W | Fetch byte address |
| cpu_ready | output | 1 | Fetch completes this cycle |
| cpu_data | output | 8 | Fetched byte, valid with cpu_ready |
| fl_rd | output | 1 | Flash read start, one cycle |
| fl_addr | output | ADDR_W | Flash read address |
| fl_rdata | input | 8 | Flash data, valid FLASH_LAT cycles after fl_rd |

## Verification
The bench builds the block with ADDR_W=6, LINE_BYTES=4, FLASH_LAT=2 and PF_BYTES=2. The 64-byte flash range lets a line-end fetch at the top address exercise read-ahead wrap to zero in a few cycles. The two-cycle latency gives a fixed wait count per miss. Because of that fixed count, the wait a demand miss sees behind an in-flight read-ahead byte is an exact figure, and so is the flash read total that shows the dropped read-ahead byte.

// File: rtl/icache_pkg.sv
// Shared types and control-bit positions for the flash instruction cache.
// Assumes: nothing beyond IEEE 1800-2017.
package icache_pkg;
    // Bit positions in the control register; software depends on them.
    localparam int CTL_CACHE_OFF_BIT = 1;
    localparam int CTL_PF_OFF_BIT    = 0;

    // Flash sequencer state.
    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_WAIT = 1'b1
    } eng_state_t;
endpackage

// File: rtl/icache_ctl_reg.sv
// Control register: holds cache-off and read-ahead-off, and produces an
// invalidate pulse on any write with cache-off set.
// Assumes: single-cycle write strobe; unused bits read zero.
module icache_ctl_reg
    import icache_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       cache_off,
    output logic       pf_off,
    output logic       inval,
    output logic [7:0] rdata
);
    logic unused_wdata_hi;

    // Store the two mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cache_off <= 1'b0;
            pf_off    <= 1'b0;
        end else if (wr) begin
            cache_off <= wdata[CTL_CACHE_OFF_BIT];
            pf_off    <= wdata[CTL_PF_OFF_BIT];
        end
    end

    // Invalidate whenever cache-off is written as one.
    assign inval = wr && wdata[CTL_CACHE_OFF_BIT];

    // Read view with unused bits forced to zero.
    always_comb begin
        rdata                    = '0;
        rdata[CTL_CACHE_OFF_BIT] = cache_off;
        rdata[CTL_PF_OFF_BIT]    = pf_off;
    end

    assign unused_wdata_hi = ^wdata[7:2];
endmodule

// File: rtl/icache_line.sv
// One cache line: tag of upper address bits, a valid bit per byte and the
// byte storage. A write to a different tag retags the line and keeps only
// the written byte valid.
// Assumes: LINE_BYTES is a power of two, at least 2.
module icache_line #(
    parameter int ADDR_W     = 12,
    parameter int LINE_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inval,
    input  logic [ADDR_W-1:0]     look_addr,
    output logic                  hit,
    output logic [7:0]            rd_byte,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    output logic [LINE_BYTES-1:0] valid
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic [TAG_W-1:0] tag;
    logic [7:0]       bytes [LINE_BYTES];

    logic [TAG_W-1:0] look_tag, wr_tag;
    logic [OFF_W-1:0] look_off, wr_off;

    assign look_tag = look_addr[ADDR_W-1:OFF_W];
    assign look_off = look_addr[OFF_W-1:0];
    assign wr_tag   = wr_addr[ADDR_W-1:OFF_W];
    assign wr_off   = wr_addr[OFF_W-1:0];

    // Tag and valid bookkeeping; invalidate wins over a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag   <= '0;
            valid <= '0;
        end else if (inval) begin
            valid <= '0;
        end else if (wr_en) begin
            if (wr_tag != tag) begin
                tag   <= wr_tag;
                valid <= LINE_BYTES'(1) << wr_off;
            end else begin
                valid[wr_off] <= 1'b1;
            end
        end
    end

    // Byte storage, one register per position.
    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                bytes[i] <= '0;
            else if (wr_en && wr_off == OFF_W'(i))
                bytes[i] <= wr_data;
        end
    end

    // Lookup: tag match plus the byte's own valid bit.
    assign hit     = (look_tag == tag) && valid[look_off];
    assign rd_byte = bytes[look_off];
endmodule

// File: rtl/icache_fill_engine.sv
// Flash sequencer: issues one read at a time, waits the fixed latency,
// captures the byte, and runs read-ahead. Demand misses outrank
// read-ahead; issuing a demand drops read-ahead not yet started.
// Assumes: flash data is valid exactly FLASH_LAT cycles after fl_rd.
module icache_fill_engine
    import icache_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int FLASH_LAT = 2,
    parameter int PF_BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              hit_ok,
    input  logic              pf_en,
    input  logic              pf_trigger,
    output logic              fl_rd,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic [7:0]        fl_rdata,
    output logic              cap_valid,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [7:0]        cap_data,
    output logic              done,
    output logic [7:0]        held
);
    localparam int CNT_W  = $clog2(FLASH_LAT + 1);
    localparam int LEFT_W = $clog2(PF_BYTES + 1);

    eng_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_demand;
    logic [ADDR_W-1:0] pf_addr;
    logic [LEFT_W-1:0] pf_left;
    logic              want_demand, issue_d, issue_p;

    // Choose what to send to flash this cycle.
    assign want_demand = cpu_req && !hit_ok && !done;
    assign issue_d     = (state == ENG_IDLE) && want_demand;
    assign issue_p     = (state == ENG_IDLE) && !want_demand && pf_en && (pf_left != '0);
    assign fl_rd       = issue_d || issue_p;
    assign fl_addr     = issue_d ? cpu_addr : pf_addr;

    // Capture point: final cycle of the latency window.
    assign cap_valid = (state == ENG_WAIT) && (cnt == '0);
    assign cap_addr  = cur_addr;
    assign cap_data  = fl_rdata;

    // Sequencer: idle, then count down the flash latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ENG_IDLE;
            cnt        <= '0;
            cur_addr   <= '0;
            cur_demand <= 1'b0;
            done       <= 1'b0;
            held       <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (fl_rd) begin
                        state      <= ENG_WAIT;
                        cnt        <= CNT_W'(FLASH_LAT - 1);
                        cur_addr   <= fl_addr;
                        cur_demand <= issue_d;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        state <= ENG_IDLE;
                        held  <= fl_rdata;
                        done  <= cur_demand;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Read-ahead bookkeeping: arm, advance, or abandon.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_addr <= '0;
            pf_left <= '0;
        end else if (!pf_en) begin
            pf_left <= '0;
        end else if (pf_trigger) begin
            pf_addr <= cpu_addr + ADDR_W'(1);
            pf_left <= LEFT_W'(PF_BYTES);
        end else if (issue_d) begin
            pf_left <= '0;
        end else if (issue_p) begin
            pf_addr <= pf_addr + ADDR_W'(1);
            pf_left <= pf_left - LEFT_W'(1);
        end
    end
endmodule

// File: rtl/flash_icache.sv
// Top of the flash instruction cache: control register, one line buffer,
// and the flash sequencer. Hits answer combinationally; misses return one
// cycle after the flash byte lands.
// Assumes: the processor holds cpu_req and cpu_addr until cpu_ready.
module flash_icache
    import icache_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int LINE_BYTES = 4,
    parameter int FLASH_LAT  = 2,
    parameter int PF_BYTES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic [7:0]        cpu_data,
    output logic              fl_rd,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic [7:0]        fl_rdata
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    logic                  cache_off, pf_off, inval;
    logic                  hit, hit_ok, pf_en, pf_trigger;
    logic [7:0]            line_byte;
    logic [LINE_BYTES-1:0] line_valid;
    logic                  cap_valid, done;
    logic [ADDR_W-1:0]     cap_addr;
    logic [7:0]            cap_data, held;

    icache_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
        .cache_off(cache_off), .pf_off(pf_off), .inval(inval), .rdata(cfg_rdata)
    );

    icache_line #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_line (
        .clk(clk), .rst_n(rst_n), .inval(inval),
        .look_addr(cpu_addr), .hit(hit), .rd_byte(line_byte),
        .wr_en(cap_valid && !cache_off), .wr_addr(cap_addr), .wr_data(cap_data),
        .valid(line_valid)
    );

    icache_fill_engine #(.ADDR_W(ADDR_W), .FLASH_LAT(FLASH_LAT), .PF_BYTES(PF_BYTES)) u_eng (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .hit_ok(hit_ok), .pf_en(pf_en), .pf_trigger(pf_trigger),
        .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_rdata(fl_rdata),
        .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_data(cap_data),
        .done(done), .held(held)
    );

    // Processor-side handshake and read-ahead trigger.
    assign hit_ok     = hit && !cache_off;
    assign pf_en      = !cache_off && !pf_off;
    assign cpu_ready  = cpu_req && (done || hit_ok);
    assign cpu_data   = done ? held : line_byte;
    assign pf_trigger = cpu_ready && pf_en &&
                        (cpu_addr[OFF_W-1:0] == OFF_W'(LINE_BYTES - 1));
endmodule

// Checker for the flash instruction cache, attached by bind below.
module flash_icache_chk #(
    parameter int ADDR_W     = 12,
    parameter int LINE_BYTES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_wr,
    input logic [7:0]            cfg_wdata,
    input logic [7:0]            cfg_rdata,
    input logic                  cpu_req,
    input logic [ADDR_W-1:0]     cpu_addr,
    input logic                  cpu_ready,
    input logic                  fl_rd,
    input logic [ADDR_W-1:0]     fl_addr,
    input logic [LINE_BYTES-1:0] line_valid
);
    AST_CFG_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cfg_rdata[7:2] == 6'd0); // R1
    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) cpu_ready |-> cpu_req); // R2
    AST_ONE_READ_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n) fl_rd |=> !fl_rd); // R3
    AST_NO_READAHEAD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[0] && fl_rd) |-> (cpu_req && fl_addr == cpu_addr)); // R5
    AST_INVALIDATE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[1]) |=> (line_valid == '0)); // R6
    AST_BYPASS_DEMAND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1] && fl_rd) |-> (cpu_req && fl_addr == cpu_addr)); // R7
endmodule

bind flash_icache flash_icache_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
    .fl_rd(fl_rd), .fl_addr(fl_addr), .line_valid(line_valid)
);

// File: tb/flash_icache_test.sv
// Directed bench: behavioural flash with two-cycle latency, a flash read
// counter, and one task per scenario.
module flash_icache_test;
    localparam int AW  = 6;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_ready;
    logic [7:0]    cpu_data;
    logic          fl_rd;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_rdata = '0;

    int errors = 0;
    int checks = 0;
    int reads  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flash_icache #(.ADDR_W(AW), .LINE_BYTES(4), .FLASH_LAT(LAT), .PF_BYTES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .cpu_data(cpu_data),
        .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_rdata(fl_rdata)
    );

    function automatic logic [7:0] flash_byte(input logic [AW-1:0] a);
        return 8'((a * 37 + 11) ^ (a >> 2));
    endfunction

    // Behavioural flash: data valid LAT cycles after the read strobe.
    logic [AW-1:0] stage_addr = '0;
    always @(posedge clk) begin
        stage_addr <= fl_addr;
        fl_rdata   <= flash_byte(stage_addr);
        if (rst_n && fl_rd) reads++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fetch(input logic [AW-1:0] a, output int waits, output logic [7:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a; waits = 0;
        #1;
        while (!cpu_ready && waits < 50) begin
            @(negedge clk); #1;
            waits++;
        end
        d = cpu_data;
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic t_config;
        chk("R1 reset value", int'(cfg_rdata), 0);
        cfg_write(8'hFF);
        chk("R1 unused bits zero", int'(cfg_rdata), 3);
        cfg_write(8'h00);
        chk("R1 cleared", int'(cfg_rdata), 0);
    endtask

    task automatic t_miss_hit;
        int w; logic [7:0] d; int n0;
        n0 = reads;
        fetch(6'd8, w, d);
        chk("R3 miss wait", w, LAT + 1);
        chk("R3 miss data", int'(d), int'(flash_byte(6'd8)));
        fetch(6'd8, w, d);
        chk("R2 hit wait", w, 0);
        chk("R2 hit data", int'(d), int'(flash_byte(6'd8)));
        chk("R2 no flash read on hit", reads - n0, 1);
    endtask

    task automatic t_readahead;
        int w; logic [7:0] d; int n0;
        n0 = reads;
        fetch(6'd9, w, d);
        fetch(6'd10, w, d);
        fetch(6'd11, w, d);
        chk("R3 line-end miss data", int'(d), int'(flash_byte(6'd11)));
        idle(8);
        chk("R4 read-ahead reads", reads - n0, 5);
        fetch(6'd12, w, d);
        chk("R4 first read-ahead hit", w, 0);
        chk("R4 first read-ahead data", int'(d), int'(flash_byte(6'd12)));
        fetch(6'd13, w, d);
        chk("R4 second read-ahead hit", w, 0);
        fetch(6'd14, w, d);
        chk("R4 beyond read-ahead misses", w, LAT + 1);
    endtask

    task automatic t_wrap;
        int w; logic [7:0] d; int n0;
        n0 = reads;
        fetch(6'd63, w, d);
        idle(8);
        chk("R9 reads after top byte", reads - n0, 3);
        fetch(6'd0, w, d);
        chk("R9 wrapped hit", w, 0);
        chk("R9 wrapped data", int'(d), int'(flash_byte(6'd0)));
        fetch(6'd1, w, d);
        chk("R9 second wrapped hit", w, 0);
    endtask

    task automatic t_no_readahead;
        int w; logic [7:0] d; int n0;
        cfg_write(8'h01);
        n0 = reads;
        fetch(6'd27, w, d);
        idle(8);
        chk("R5 only demand read", reads - n0, 1);
        fetch(6'd28, w, d);
        chk("R5 next byte misses", w, LAT + 1);
        cfg_write(8'h00);
    endtask

    task automatic t_invalidate;
        int w; logic [7:0] d;
        fetch(6'd20, w, d);
        fetch(6'd20, w, d);
        chk("R6 held before disable", w, 0);
        cfg_write(8'h02);
        cfg_write(8'h00);
        fetch(6'd20, w, d);
        chk("R6 empty after re-enable", w, LAT + 1);
        chk("R6 refill data", int'(d), int'(flash_byte(6'd20)));
    endtask

    task automatic t_bypass;
        int w; logic [7:0] d; int n0;
        cfg_write(8'h02);
        n0 = reads;
        fetch(6'd5, w, d);
        chk("R7 first bypass wait", w, LAT + 1);
        fetch(6'd5, w, d);
        chk("R7 repeat bypass wait", w, LAT + 1);
        chk("R7 repeat bypass data", int'(d), int'(flash_byte(6'd5)));
        fetch(6'd7, w, d);
        idle(8);
        chk("R7 no read-ahead in bypass", reads - n0, 3);
        cfg_write(8'h00);
    endtask

    task automatic t_abandon;
        int w; logic [7:0] d; int n0;
        n0 = reads;
        fetch(6'd35, w, d);
        fetch(6'd50, w, d);
        chk("R8 demand waits behind one byte", w, 5);
        chk("R8 demand data", int'(d), int'(flash_byte(6'd50)));
        idle(8);
        chk("R8 rest of read-ahead dropped", reads - n0, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_config();
        t_miss_hit();
        t_readahead();
        t_wrap();
        t_no_readahead();
        t_invalidate();
        t_bypass();
        t_abandon();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule